// File: doc/BRIEF.md
# Control Write Command SPI Responder

This block is the device-side end of a serial control channel. A host drives a chip select, a serial clock and a data line (SPI mode 0: data sampled on the rising clock edge, changed on the falling edge). The block receives 32-bit words, most significant bit first. The first word of each frame is a command header. When the header is a valid control write, the data words that follow are written into a local register bank at consecutive addresses. The write port is a plain address, selector, data and one-cycle strobe.

While the frame runs, the block sends back every received word exactly one word later. The host can therefore compare what came back with what it sent. The first returned word is all zeros. The host adds one trailing word after the last data word, and during that word the final data word is returned.

The serial pins are sampled and synchronized in the system clock domain. All decoding and all register writes happen in that domain.

Top module: `ctrl_cmd_responder`

## Requirements
- R1: A header is accepted only when three conditions hold: bit 31 is 0 (control), bit 29 is 1 (write), and the total count of ones over all 32 bits is odd. For an accepted header, bits 27:24 give the selector used on every write of the frame and bits 23:8 give the first register address.
- R2: After an accepted header, the data words are written in the order they arrive. The number of writes is bits 7:1 of the header plus one, from 1 up to 128. Each data word is assembled MSB first and written to the address one above the previous write.
- R3: When a header has even parity, the frame produces no register write, but its words are still returned on MISO.
- R4: When a header has bit 31 set or bit 29 clear, the frame produces no register write.
- R5: During the first word of every frame, MISO is 0.
- R6: During word k of a frame (k ≥ 1), MISO carries word k−1 as received, bit for bit. This includes the trailing word, which returns the last data word.
- R7: Words received after the announced count, including the trailing word and any further words, produce no write.
- R8: Each register write is announced by a strobe that is high for exactly one system clock cycle.
- R9: Raising chip select ends the frame. A partly received word is discarded, writes already issued stay in place, and the next frame starts again with a header.
- R10: The register address increments with wrap-around, so the address after 0xFFFF is 0x0000.
- R11: After reset, the write strobe is low and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiSclk | input | 1 | Serial clock from the host |
| spiCsN | input | 1 | Active-low chip select |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial data to the host, the received stream one word late |
| regWrStrobe | output | 1 | One-cycle write strobe to the register bank |
| regWrAddr | output | 16 | Register address of the write |
| regWrSel | output | 4 | Selector taken from the header |
| regWrData | output | 32 | Data word of the write |

## Verification
The hardest situations to reach from the pins lie at frame edges. One is a chip select that rises in the middle of a data word after some writes have already been issued. Another is a frame that keeps clocking words after its announced count. A third is a start address that crosses 0xFFFF. The bench drives the serial lines bit by bit from a word list, so it can stop after any bit count or append extra words. It then runs a normal frame directly afterwards to show that the header position was reset. Sweeping the count field up to 128 exercises the full length range together with the one-word echo delay.

// File: rtl/ctrl_resp_pkg.sv
package ctrl_resp_pkg;

  // Header field positions: the host encodes them, so they are fixed.
  localparam int HdrNotCtrlBit = 31;
  localparam int HdrWriteBit   = 29;
  localparam int HdrSelLsb     = 24;
  localparam int HdrAddrLsb    = 8;
  localparam int HdrCntLsb     = 1;

  // Strobes from control to datapath.
  typedef struct packed {
    logic hdrLoad;  // latch selector and start address from the current word
    logic wrIssue;  // issue a register write with the current word
  } ctrlStrobes_t;

endpackage

// File: rtl/ctrl_resp_datapath.sv
module ctrl_resp_datapath
  import ctrl_resp_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int ADDR_W      = 16,
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkPin,
  input  logic              csNPin,
  input  logic              mosiPin,
  input  ctrlStrobes_t      strobes,
  output logic              misoPin,
  output logic              csActive,
  output logic              wordDone,
  output logic [WORD_W-1:0] rxWord,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [SEL_W-1:0]  wrSel,
  output logic [WORD_W-1:0] wrData
);

  localparam int BitCntW = $clog2(WORD_W);
  localparam logic [BitCntW-1:0] LastBit = BitCntW'(WORD_W - 1);

  // Pin synchronizers
  logic [SYNC_STAGES-1:0] sclkSync, csSync, mosiSync;
  logic sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkPin};
      csSync   <= {csSync[SYNC_STAGES-2:0], csNPin};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosiPin};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
    end
  end

  logic sclkNow, mosiNow, sclkRise, sclkFall;
  assign sclkNow  = sclkSync[SYNC_STAGES-1];
  assign mosiNow  = mosiSync[SYNC_STAGES-1];
  assign csActive = ~csSync[SYNC_STAGES-1];
  assign sclkRise = csActive & sclkNow & ~sclkPrev;
  assign sclkFall = csActive & ~sclkNow & sclkPrev;

  // Receive shifter
  logic [BitCntW-1:0] bitCnt;
  logic [WORD_W-1:0]  rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else if (!csActive) begin
      bitCnt  <= '0;
    end else if (sclkRise) begin
      rxShift <= {rxShift[WORD_W-2:0], mosiNow};
      bitCnt  <= (bitCnt == LastBit) ? '0 : bitCnt + 1'b1;
    end
  end

  assign rxWord   = {rxShift[WORD_W-2:0], mosiNow};
  assign wordDone = sclkRise & (bitCnt == LastBit);

  // Echo shifter: the word just completed goes out during the next word
  logic [WORD_W-1:0] txShift;
  logic holdFirst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift   <= '0;
      holdFirst <= 1'b0;
    end else if (!csActive) begin
      txShift   <= '0;
      holdFirst <= 1'b0;
    end else if (wordDone) begin
      txShift   <= rxWord;
      holdFirst <= 1'b1;
    end else if (sclkFall) begin
      if (holdFirst) holdFirst <= 1'b0;
      else           txShift   <= {txShift[WORD_W-2:0], 1'b0};
    end
  end

  assign misoPin = txShift[WORD_W-1];

  // Register write port
  logic [ADDR_W-1:0] addrCnt;
  logic [SEL_W-1:0]  selReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt  <= '0;
      selReg   <= '0;
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrSel    <= '0;
      wrData   <= '0;
    end else begin
      wrStrobe <= 1'b0;
      if (strobes.hdrLoad) begin
        addrCnt <= rxWord[HdrAddrLsb +: ADDR_W];
        selReg  <= rxWord[HdrSelLsb +: SEL_W];
      end else if (strobes.wrIssue) begin
        wrStrobe <= 1'b1;
        wrAddr   <= addrCnt;
        wrSel    <= selReg;
        wrData   <= rxWord;
        addrCnt  <= addrCnt + 1'b1;
      end
    end
  end

  // R2: a write is only requested when a whole word has just arrived
  p_issue_on_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrIssue |-> wordDone);

  // R8: the strobe never lasts two cycles
  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

endmodule

// File: rtl/ctrl_resp_control.sv
module ctrl_resp_control
  import ctrl_resp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              wordDone,
  input  logic [WORD_W-1:0] rxWord,
  output ctrlStrobes_t      strobes,
  output logic              headerPhase
);

  localparam int MaxCount = 1 << CNT_W;

  logic             expectHdr;
  logic [CNT_W:0]   writesLeft;
  logic             hdrOk;
  logic [CNT_W:0]   hdrCount;

  assign hdrOk = ~rxWord[HdrNotCtrlBit] & rxWord[HdrWriteBit] & (^rxWord);
  assign hdrCount = {1'b0, rxWord[HdrCntLsb +: CNT_W]} + 1'b1;

  always_comb begin
    strobes.hdrLoad = wordDone & expectHdr & hdrOk;
    strobes.wrIssue = wordDone & ~expectHdr & (writesLeft != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expectHdr  <= 1'b1;
      writesLeft <= '0;
    end else if (!csActive) begin
      expectHdr  <= 1'b1;
      writesLeft <= '0;
    end else if (wordDone) begin
      if (expectHdr) begin
        expectHdr  <= 1'b0;
        writesLeft <= hdrOk ? hdrCount : '0;
      end else if (writesLeft != '0) begin
        writesLeft <= writesLeft - 1'b1;
      end
    end
  end

  assign headerPhase = expectHdr;

  // R7: outstanding writes never exceed the largest count a header can hold
  p_left_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    writesLeft <= (CNT_W+1)'(MaxCount));

  // R9: nothing is written while chip select is inactive
  p_no_write_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |-> !strobes.wrIssue);

endmodule

// File: rtl/ctrl_cmd_responder.sv
module ctrl_cmd_responder
  import ctrl_resp_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int ADDR_W      = 16,
  parameter int SEL_W       = 4,
  parameter int CNT_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic              regWrStrobe,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [SEL_W-1:0]  regWrSel,
  output logic [WORD_W-1:0] regWrData
);

  ctrlStrobes_t      strobes;
  logic              csActive, wordDone, headerPhase;
  logic [WORD_W-1:0] rxWord;

  ctrl_resp_datapath #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk(clk), .rstN(rstN),
    .sclkPin(spiSclk), .csNPin(spiCsN), .mosiPin(spiMosi),
    .strobes(strobes),
    .misoPin(spiMiso), .csActive(csActive), .wordDone(wordDone), .rxWord(rxWord),
    .wrStrobe(regWrStrobe), .wrAddr(regWrAddr), .wrSel(regWrSel), .wrData(regWrData)
  );

  ctrl_resp_control #(
    .WORD_W(WORD_W), .CNT_W(CNT_W)
  ) i_control (
    .clk(clk), .rstN(rstN),
    .csActive(csActive), .wordDone(wordDone), .rxWord(rxWord),
    .strobes(strobes), .headerPhase(headerPhase)
  );

  // Checker state: previous write address inside the current frame
  logic [ADDR_W-1:0] prevAddr;
  logic              prevValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAddr  <= '0;
      prevValid <= 1'b0;
    end else if (regWrStrobe) begin
      prevAddr  <= regWrAddr;
      prevValid <= 1'b1;
    end else if (!csActive) begin
      prevValid <= 1'b0;
    end
  end

  // R2 / R10: each write in a frame lands one address above the last, with wrap
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrStrobe && prevValid) |-> (regWrAddr == prevAddr + 1'b1));

  // R5: the header word period returns zeros
  p_first_echo_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (csActive && headerPhase) |-> !spiMiso);

endmodule

// File: tb/test_ctrl_cmd_responder.sv
module test_ctrl_cmd_responder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0;
  logic spiMiso, regWrStrobe;
  logic [15:0] regWrAddr;
  logic [3:0]  regWrSel;
  logic [31:0] regWrData;

  always #2.5 clk = ~clk;  // 200 MHz

  ctrl_cmd_responder i_ctrl_cmd_responder (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .regWrStrobe(regWrStrobe), .regWrAddr(regWrAddr),
    .regWrSel(regWrSel), .regWrData(regWrData)
  );

  int nTests = 0, nFail = 0;
  logic [31:0] txWords [0:139];
  logic [31:0] rxEcho  [0:139];
  logic [15:0] wAddr [0:255];
  logic [3:0]  wSel  [0:255];
  logic [31:0] wData [0:255];
  int wCnt = 0;
  int longStrobes = 0;
  logic prevStrobe = 1'b0;

  // Write monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (regWrStrobe) begin
      if (wCnt < 256) begin
        wAddr[wCnt] = regWrAddr;
        wSel[wCnt]  = regWrSel;
        wData[wCnt] = regWrData;
      end
      wCnt++;
      if (prevStrobe) longStrobes++;
    end
    prevStrobe = regWrStrobe;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkHdr(input bit notCtrl, input bit wr, input logic [3:0] sel,
                                        input logic [15:0] addr, input int cnt, input bit badPar);
    logic [31:0] h;
    h = {notCtrl, 1'b0, wr, 1'b0, sel, addr, 7'(cnt - 1), 1'b0};
    h[0] = ~(^h[31:1]);
    if (badPar) h[0] = ~h[0];
    return h;
  endfunction

  task automatic runFrame(input int nWords, input int abortBits);
    int total;
    total = (abortBits >= 0) ? abortBits : nWords * 32;
    wCnt = 0;
    for (int i = 0; i < 140; i++) rxEcho[i] = '0;
    @(negedge clk);
    spiCsN = 1'b0;
    repeat (6) @(negedge clk);
    for (int b = 0; b < total; b++) begin
      spiMosi = txWords[b / 32][31 - (b % 32)];
      repeat (6) @(negedge clk);
      rxEcho[b / 32] = {rxEcho[b / 32][30:0], spiMiso};
      spiSclk = 1'b1;
      repeat (6) @(negedge clk);
      spiSclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    spiCsN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic checkWrites(input int expN, input logic [15:0] base, input logic [3:0] sel, input string req);
    check(wCnt == expN, {req, " write count"}, 64'(wCnt), 64'(expN));
    for (int i = 0; i < expN && i < wCnt; i++) begin
      logic [15:0] ea;
      ea = base + 16'(i);
      check(wAddr[i] == ea && wSel[i] == sel && wData[i] == txWords[1 + i],
            {req, " write content"}, {wSel[i], wAddr[i], wData[i]}, {sel, ea, txWords[1 + i]});
    end
  endtask

  task automatic checkEcho(input int nWords);
    check(rxEcho[0] == 32'h0, "R5 first word zero", 64'(rxEcho[0]), 64'h0);
    for (int k = 1; k < nWords; k++)
      check(rxEcho[k] == txWords[k - 1], "R6 echo delayed one word", 64'(rxEcho[k]), 64'(txWords[k - 1]));
  endtask

  task automatic fillData(input int first, input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++)
      txWords[first + i] = seed ^ (32'(i) * 32'h01030507) ^ {16'(i), 16'hC3A5};
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : stim
    int lens [7] = '{1, 2, 3, 4, 5, 8, 128};
    repeat (5) @(negedge clk);
    // R11: reset state
    check(regWrStrobe == 1'b0, "R11 strobe low in reset", 64'(regWrStrobe), 64'h0);
    check(spiMiso == 1'b0, "R11 miso low in reset", 64'(spiMiso), 64'h0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(regWrStrobe == 1'b0 && spiMiso == 1'b0, "R11 idle after reset", {regWrStrobe, spiMiso}, 64'h0);

    // R1 R2 R5 R6 R7: count sweep
    foreach (lens[j]) begin
      int n;
      logic [15:0] base;
      logic [3:0] sel;
      n = lens[j];
      base = 16'h1000 + 16'(n * 3);
      sel = 4'(n);
      txWords[0] = mkHdr(1'b0, 1'b1, sel, base, n, 1'b0);
      fillData(1, n, 32'hA5000000 ^ (32'(n) << 16));
      txWords[n + 1] = 32'h5A5A0F0F;
      runFrame(n + 2, -1);
      checkWrites(n, base, sel, "R1 R2 R7");
      checkEcho(n + 2);
    end

    // R3: bad parity, still echoed
    txWords[0] = mkHdr(1'b0, 1'b1, 4'h3, 16'h0200, 3, 1'b1);
    fillData(1, 4, 32'h11112222);
    runFrame(5, -1);
    check(wCnt == 0, "R3 parity error no write", 64'(wCnt), 64'h0);
    checkEcho(5);

    // R4: data flag set
    txWords[0] = mkHdr(1'b1, 1'b1, 4'h3, 16'h0200, 2, 1'b0);
    fillData(1, 3, 32'h33334444);
    runFrame(4, -1);
    check(wCnt == 0, "R4 non-control header no write", 64'(wCnt), 64'h0);

    // R4: read (write bit clear)
    txWords[0] = mkHdr(1'b0, 1'b0, 4'h3, 16'h0200, 2, 1'b0);
    runFrame(4, -1);
    check(wCnt == 0, "R4 read header no write", 64'(wCnt), 64'h0);

    // R10: address wrap
    txWords[0] = mkHdr(1'b0, 1'b1, 4'hE, 16'hFFFE, 4, 1'b0);
    fillData(1, 5, 32'hDEAD0000);
    runFrame(6, -1);
    checkWrites(4, 16'hFFFE, 4'hE, "R10 wrap");
    if (wCnt >= 3)
      check(wAddr[2] == 16'h0000, "R10 wrapped address", 64'(wAddr[2]), 64'h0);

    // R7: extra words after the count
    txWords[0] = mkHdr(1'b0, 1'b1, 4'h6, 16'h0040, 2, 1'b0);
    fillData(1, 6, 32'h0BADF00D);
    runFrame(7, -1);
    checkWrites(2, 16'h0040, 4'h6, "R7 extra words ignored");
    checkEcho(7);

    // R9: abort mid data word after two complete data words
    txWords[0] = mkHdr(1'b0, 1'b1, 4'h9, 16'h0300, 4, 1'b0);
    fillData(1, 5, 32'h76543210);
    runFrame(6, 3 * 32 + 10);
    checkWrites(2, 16'h0300, 4'h9, "R9 abort keeps issued writes");
    // R9: next frame starts with a header again
    txWords[0] = mkHdr(1'b0, 1'b1, 4'h2, 16'h0777, 1, 1'b0);
    fillData(1, 2, 32'hCAFE0001);
    runFrame(3, -1);
    checkWrites(1, 16'h0777, 4'h2, "R9 fresh frame after abort");
    checkEcho(3);

    // R8: single-cycle strobes across the whole run
    check(longStrobes == 0, "R8 strobe one cycle", 64'(longStrobes), 64'h0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule